// File: doc/BRIEF.md
# Digitally Trimmed RTC Timebase

This block is the timebase of a real-time clock. A 4096 Hz tick enable, derived outside the block from a 32 kHz crystal clock, drives a prescaler. The prescaler advances an 8-bit subsecond count, and that count rolls over into a 32-bit seconds count. Each second has 256 subsecond steps. An untrimmed step lasts 16 ticks.

Crystals drift, so the block applies a sign-magnitude correction. It does not touch the oscillator. Once every ten seconds it changes the length of a single subsecond step, so a number of 4096 Hz periods are inserted into the timebase or removed from it. The changed step is the first step after every tenth seconds rollover. One unit of magnitude moves time by 1/(4096*10), which is about 24.4 ppm. A magnitude of 15 gives about 366 ppm.

Software writes the trim sign and magnitude, and can change them at any time. The block samples them only at the edge where the corrected step begins.

Top module: `rtc_trim_timebase`

## Requirements
- R1: While rst_n is low, on every clock edge, the block clears subsec, seconds, the prescaler and the ten-second interval counter to zero.
- R2: A qualifying tick is a clock edge where tick_4k and run_en are both high. Outside the corrected step, subsec increases by exactly one after every 16th qualifying tick. The new value is visible after the edge that carries that 16th tick.
- R3: When subsec is 255 and a step completes, subsec wraps to 0 and seconds increases by one on the same edge. Seconds changes at no other time.
- R4: On an edge where tick_4k or run_en is low, subsec, seconds, the prescaler and the ten-second counter all keep their values.
- R5: Only one step is corrected: the first step after each tenth seconds rollover, which is the step from subsec 0 to 1 when seconds has just become a nonzero multiple of 10. Every other step lasts 16 qualifying ticks.
- R6: When trim_slow is 1 and trim_mag is not 0, the corrected step lasts 16 + trim_mag qualifying ticks. This slows the clock.
- R7: When trim_slow is 0 and trim_mag is not 0, the corrected step lasts 16 - trim_mag qualifying ticks. This speeds the clock up. A magnitude of 15 gives a 1-tick step.
- R8: When trim_mag is 0, the corrected step lasts 16 ticks, whatever trim_slow is.
- R9: The length of the corrected step is taken from trim_slow and trim_mag as they stand at the edge that completes the step before it. Changing them while the corrected step is in progress does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_4k | input | 1 | 4096 Hz tick enable, one clock wide |
| run_en | input | 1 | Run enable. When low, all counting state holds |
| trim_slow | input | 1 | Trim sign: 1 lengthens the corrected step, 0 shortens it |
| trim_mag | input | 4 | Trim magnitude in 4096 Hz periods. 0 disables the correction |
| subsec | output | 8 | Subsecond count, 1/256 s units |
| seconds | output | 32 | Seconds count |

## Verification
Every counter is a single register stage, so a new subsec or seconds value is due one edge after the qualifying tick that completes a step. A trim value takes effect one whole step after the edge that samples it.

The driver plans each step before it drives any ticks. It pushes the expected subsec value, the expected seconds value and the expected number of qualifying ticks. The monitor reads the outputs at falling edges, between the edge that updates them and the next one. Each time the outputs change, the monitor compares them against the oldest planned step, so a step that comes early or late shows up as a wrong tick count.

Disabled and idle cycles are mixed into the ticks of some steps. These cycles must not count.

// File: rtl/rtc_trim_pkg.sv
// Shared helpers for the trimmed timebase.
// Assumes the base division is larger than the largest trim magnitude,
// so a shortened step never reaches zero ticks.
package rtc_trim_pkg;

    // Terminal count for one subsecond step.
    // apply selects the corrected step; slow selects lengthen or shorten.
    function automatic int unsigned step_limit(input int unsigned base,
                                               input int unsigned mag,
                                               input logic        slow,
                                               input logic        apply);
        if (!apply || mag == 0)
            return base;
        else if (slow)
            return base + mag;
        else
            return base - mag;
    endfunction

endpackage

// File: rtl/rtc_trim_prescaler.sv
// Prescaler for the 4096 Hz tick enable.
// It counts qualifying ticks up to the terminal count held for the current
// step, then pulses step_o. The terminal count for the next step is loaded
// from next_limit on the same edge as that pulse, so a step already in
// progress keeps its length.
// Assumes next_limit is between 1 and 2**LIM_W-1.
module rtc_trim_prescaler #(
    parameter int BASE_DIV = 16,
    parameter int LIM_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [LIM_W-1:0] next_limit,
    output logic             step_o,
    output logic [LIM_W-1:0] cnt_o,
    output logic [LIM_W-1:0] limit_o
);
    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W-1:0] limit_q;
    logic             at_term;

    // Last tick of the current step.
    assign at_term = (cnt_q == limit_q - LIM_W'(1));
    assign step_o  = adv && at_term;
    assign cnt_o   = cnt_q;
    assign limit_o = limit_q;

    // Count ticks; wrap and load the next terminal count when a step ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            limit_q <= LIM_W'(BASE_DIV);
        end else if (adv) begin
            cnt_q <= at_term ? '0 : cnt_q + LIM_W'(1);
            if (at_term)
                limit_q <= next_limit;
        end
    end
endmodule

// File: rtl/rtc_trim_interval.sv
// Modulo-PERIOD counter of seconds rollovers.
// last_o is high during the final second of each trim interval.
// Assumes PERIOD >= 2.
module rtc_trim_interval #(
    parameter int PERIOD = 10,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_wrap,
    output logic last_o
);
    logic [CNT_W-1:0] cnt_q;

    assign last_o = (cnt_q == CNT_W'(PERIOD - 1));

    // Advance once per seconds rollover and wrap at PERIOD.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (sec_wrap)
            cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/rtc_trim_counters.sv
// Subsecond and seconds counters.
// The subsecond count advances by one on each step. When it wraps, it
// carries into the seconds count. The seconds count wraps silently.
module rtc_trim_counters #(
    parameter int SUB_W = 8,
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic             sub_wrap,
    output logic [SUB_W-1:0] sub_o,
    output logic [SEC_W-1:0] sec_o
);
    logic [SUB_W-1:0] sub_q;
    logic [SEC_W-1:0] sec_q;

    assign sub_wrap = step && (sub_q == {SUB_W{1'b1}});
    assign sub_o    = sub_q;
    assign sec_o    = sec_q;

    // Step the subsecond count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sub_q <= '0;
        else if (step)
            sub_q <= sub_q + SUB_W'(1);
    end

    // Carry subsecond wraps into the seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_q <= '0;
        else if (sub_wrap)
            sec_q <= sec_q + SEC_W'(1);
    end
endmodule

// File: rtl/rtc_trim_timebase.sv
// Top level of the digitally trimmed RTC timebase.
// It gates the 4096 Hz tick with the run enable, feeds the prescaler and
// the counters, and chooses the terminal count for the step that follows
// each tenth seconds rollover. The trim inputs are sampled only on that
// edge.
// Assumes tick_4k is synchronous to clk and at most one clock wide.
module rtc_trim_timebase #(
    parameter int BASE_DIV    = 16,
    parameter int TRIM_W      = 4,
    parameter int SUB_W       = 8,
    parameter int SEC_W       = 32,
    parameter int TRIM_PERIOD = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_4k,
    input  logic              run_en,
    input  logic              trim_slow,
    input  logic [TRIM_W-1:0] trim_mag,
    output logic [SUB_W-1:0]  subsec,
    output logic [SEC_W-1:0]  seconds
);
    import rtc_trim_pkg::*;

    localparam int LIM_W = $clog2(BASE_DIV + (1 << TRIM_W));

    logic             adv;
    logic             step;
    logic             sub_wrap;
    logic             period_last;
    logic             trim_due;
    logic [LIM_W-1:0] next_limit;
    logic [LIM_W-1:0] pcnt;
    logic [LIM_W-1:0] cur_limit;

    assign adv      = tick_4k && run_en;
    assign trim_due = sub_wrap && period_last;

    // Terminal count for the step that begins on this edge.
    always_comb begin
        next_limit = LIM_W'(step_limit(BASE_DIV, int'(trim_mag), trim_slow, trim_due));
    end

    rtc_trim_prescaler #(
        .BASE_DIV (BASE_DIV),
        .LIM_W    (LIM_W)
    ) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .next_limit (next_limit),
        .step_o     (step),
        .cnt_o      (pcnt),
        .limit_o    (cur_limit)
    );

    rtc_trim_counters #(
        .SUB_W (SUB_W),
        .SEC_W (SEC_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .sub_wrap (sub_wrap),
        .sub_o    (subsec),
        .sec_o    (seconds)
    );

    rtc_trim_interval #(
        .PERIOD (TRIM_PERIOD)
    ) u_intv (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_wrap (sub_wrap),
        .last_o   (period_last)
    );
endmodule

// File: rtl/rtc_trim_timebase_chk.sv
// Property checker for rtc_trim_timebase. It is attached with bind and
// watches the ports, the prescaler count and the held terminal count.
module rtc_trim_timebase_chk #(
    parameter int BASE_DIV = 16,
    parameter int TRIM_W   = 4,
    parameter int SUB_W    = 8,
    parameter int SEC_W    = 32,
    parameter int LIM_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_4k,
    input logic             run_en,
    input logic [SUB_W-1:0] subsec,
    input logic [SEC_W-1:0] seconds,
    input logic [LIM_W-1:0] pcnt,
    input logic [LIM_W-1:0] cur_limit,
    input logic             step
);
    // R4: without a qualifying tick, nothing moves.
    p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_4k && run_en) |=> ($stable(subsec) && $stable(seconds) && $stable(pcnt)));

    // R2: the subsecond count only ever moves up by one.
    p_subsec_plus_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(subsec) |-> (subsec == $past(subsec) + SUB_W'(1)));

    // R2: the prescaler count stays below the held terminal count.
    p_pcnt_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt < cur_limit);

    // R3: seconds move only when the subsecond count wraps from all ones.
    p_sec_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seconds) |-> (subsec == '0 && $past(subsec) == {SUB_W{1'b1}}));

    // R3: seconds advance by exactly one.
    p_sec_plus_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seconds) |-> (seconds == $past(seconds) + SEC_W'(1)));

    // R5: the terminal count stays within the base plus or minus the largest magnitude.
    p_limit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_limit >= LIM_W'(BASE_DIV - (1 << TRIM_W) + 1)) &&
        (cur_limit <= LIM_W'(BASE_DIV + (1 << TRIM_W) - 1)));

    // R9: the terminal count changes only at a step boundary.
    p_limit_stable_midstep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cur_limit));
endmodule

bind rtc_trim_timebase rtc_trim_timebase_chk #(
    .BASE_DIV (BASE_DIV),
    .TRIM_W   (TRIM_W),
    .SUB_W    (SUB_W),
    .SEC_W    (SEC_W),
    .LIM_W    (LIM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_4k   (tick_4k),
    .run_en    (run_en),
    .subsec    (subsec),
    .seconds   (seconds),
    .pcnt      (pcnt),
    .cur_limit (cur_limit),
    .step      (step)
);

// File: tb/rtc_trim_timebase_bench.sv
// Scoreboard bench for rtc_trim_timebase.
// The driver plans each step, pushes it as an expected item and then
// drives its ticks. The monitor pops one item on every output change.
module rtc_trim_timebase_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic        clk       = 1'b0;
    logic        rst_n     = 1'b0;
    logic        tick_4k   = 1'b0;
    logic        run_en    = 1'b0;
    logic        trim_slow = 1'b0;
    logic [3:0]  trim_mag  = 4'd0;
    logic [7:0]  subsec;
    logic [31:0] seconds;

    typedef struct {
        int unsigned sub;
        int unsigned sec;
        int unsigned len;
        string       req;
    } exp_item_t;

    exp_item_t   exp_q[$];
    int          checks = 0;
    int          fails  = 0;
    int unsigned tick_total = 0;
    int unsigned tick_mark  = 0;
    logic [39:0] last_obs   = '0;
    bit          mon_on     = 1'b0;
    bit          done       = 1'b0;
    int unsigned exp_sub    = 0;
    int unsigned exp_sec    = 0;

    rtc_trim_timebase u_rtc_trim_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_4k   (tick_4k),
        .run_en    (run_en),
        .trim_slow (trim_slow),
        .trim_mag  (trim_mag),
        .subsec    (subsec),
        .seconds   (seconds)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count qualifying ticks as the design sees them.
    always @(posedge clk) begin
        if (rst_n && tick_4k && run_en)
            tick_total++;
    end

    // Monitor: on each output change, pop the oldest planned step and compare.
    always @(negedge clk) begin
        if (mon_on && {seconds, subsec} != last_obs) begin
            exp_item_t it;
            int unsigned got_len;
            got_len   = tick_total - tick_mark;
            tick_mark = tick_total;
            last_obs  = {seconds, subsec};
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2: unplanned change to sec=%0d sub=%0d, expected no change",
                         seconds, subsec);
            end else begin
                it = exp_q.pop_front();
                if (subsec != it.sub[7:0] || seconds != it.sec || got_len != it.len) begin
                    fails++;
                    $display("FAIL %s: actual sec=%0d sub=%0d ticks=%0d, expected sec=%0d sub=%0d ticks=%0d",
                             it.req, seconds, subsec, got_len, it.sec, it.sub, it.len);
                end
            end
        end
    end

    // Record one check and report it if it fails.
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one qualifying tick. In gap mode, first drive a disabled tick
    // and an idle cycle, neither of which may count (R4).
    task automatic one_tick(input bit gap);
        if (gap) begin
            @(negedge clk); tick_4k = 1'b1; run_en = 1'b0;
            @(negedge clk); tick_4k = 1'b0; run_en = 1'b1;
        end
        @(negedge clk); tick_4k = 1'b1; run_en = 1'b1;
    endtask

    // Plan and drive n steps. poke >= 0 writes a new trim after that many
    // ticks of a corrected step.
    task automatic run_steps(input int n, input bit gap, input int poke,
                             input bit poke_slow, input logic [3:0] poke_mag);
        for (int s = 0; s < n; s++) begin
            exp_item_t it;
            bit trimmed;
            trimmed = (exp_sub == 0) && (exp_sec != 0) && (exp_sec % 10 == 0);
            if (!trimmed) begin
                it.len = 16;
                it.req = (exp_sub == 255) ? "R3" : "R2";
            end else if (trim_mag == 0) begin
                it.len = 16;
                it.req = "R8";
            end else if (trim_slow) begin
                it.len = 16 + trim_mag;
                it.req = (poke >= 0) ? "R9" : "R6";
            end else begin
                it.len = 16 - trim_mag;
                it.req = "R7";
            end
            if (!trimmed && exp_sub == 1 && exp_sec % 10 == 0 && exp_sec != 0)
                it.req = "R5";
            exp_sub = (exp_sub + 1) % 256;
            if (exp_sub == 0) exp_sec++;
            it.sub = exp_sub;
            it.sec = exp_sec;
            exp_q.push_back(it);
            for (int k = 0; k < int'(it.len); k++) begin
                if (trimmed && poke >= 0 && k == poke) begin
                    trim_slow = poke_slow;
                    trim_mag  = poke_mag;
                end
                one_tick(gap);
            end
        end
    endtask

    // Steps until the given second is entered, plus a few more.
    function automatic int steps_to(input int unsigned sec, input int extra);
        return int'(sec * 256 - (exp_sec * 256 + exp_sub)) + extra;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [39:0] held;
        // R1: reset clears the counters.
        trim_slow = 1'b1; trim_mag = 4'd9; tick_4k = 1'b1; run_en = 1'b1;
        repeat (4) @(negedge clk);
        check(subsec == 8'd0, "R1", "subsec in reset", subsec, 0);
        check(seconds == 32'd0, "R1", "seconds in reset", seconds, 0);
        tick_4k = 1'b0; run_en = 1'b0; trim_mag = 4'd0;
        rst_n = 1'b1;
        @(negedge clk);
        tick_mark = tick_total;
        last_obs  = {seconds, subsec};
        mon_on    = 1'b1;

        // R2, R3, R4: disabled and idle cycles mixed in, across a subsecond wrap.
        run_steps(300, 1'b1, -1, 1'b0, 4'd0);

        // R4: a long disabled stretch in the middle of a step keeps every count.
        run_steps(1, 1'b0, -1, 1'b0, 4'd0);
        one_tick(1'b0);
        one_tick(1'b0);
        @(negedge clk); tick_4k = 1'b1; run_en = 1'b0;
        @(negedge clk);
        held = {seconds, subsec};
        repeat (40) @(negedge clk);
        check({seconds, subsec} == held, "R4", "outputs while disabled", {seconds, subsec}, held);
        // Finish the step: 14 more ticks, planned by hand.
        begin
            exp_item_t it;
            exp_sub = (exp_sub + 1) % 256;
            if (exp_sub == 0) exp_sec++;
            it.sub = exp_sub; it.sec = exp_sec; it.len = 16; it.req = "R4";
            exp_q.push_back(it);
            tick_mark = tick_total - 2;
            for (int k = 0; k < 14; k++) one_tick(1'b0);
        end

        // R8: magnitude 0 with slow sign, so the step after second 10 stays 16 ticks.
        trim_slow = 1'b1; trim_mag = 4'd0;
        run_steps(steps_to(10, 3), 1'b0, -1, 1'b0, 4'd0);

        // R6 and R9: slow by 3, then rewrite to fast by 15 five ticks into the corrected step.
        trim_slow = 1'b1; trim_mag = 4'd3;
        run_steps(steps_to(20, 3), 1'b0, 5, 1'b0, 4'd15);

        // R7: fast by 15 gives a one-tick step after second 30.
        check(trim_slow == 1'b0 && trim_mag == 4'd15, "R9", "trim rewritten mid-step", trim_mag, 15);
        run_steps(steps_to(30, 3), 1'b0, -1, 1'b0, 4'd0);

        @(negedge clk); tick_4k = 1'b0; run_en = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5", "planned steps not seen", exp_q.size(), 0);
        check(seconds == 32'd30, "R3", "seconds at end", seconds, 30);
        check(subsec == 8'd3, "R2", "subsec at end", subsec, 3);

        // R1: a mid-run reset clears everything.
        mon_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(subsec == 8'd0, "R1", "subsec after reset", subsec, 0);
        check(seconds == 32'd0, "R1", "seconds after reset", seconds, 0);
        rst_n = 1'b1;
        // R1: the prescaler restarts from zero, so the first step takes exactly 16 ticks.
        for (int k = 0; k < 15; k++) one_tick(1'b0);
        @(negedge clk); tick_4k = 1'b0;
        check(subsec == 8'd0, "R1", "subsec after 15 ticks", subsec, 0);
        one_tick(1'b0);
        @(negedge clk); tick_4k = 1'b0;
        check(subsec == 8'd1, "R1", "subsec after 16 ticks", subsec, 1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule